// File: doc/BRIEF.md
# Remote-Key Tone Setting Controller

This block turns decoded remote-control key events into command bytes for a two-channel audio processor. It stores the current volume, left and right speaker attenuation, treble, bass, loudness and mute. Each key press moves one of these settings by one step and stops at the range limits. After every accepted change the block builds the processor's command byte. This byte carries the register prefix and a field that mixes a coarse part and a fine part. The byte is queued in a small FIFO, and an I2C master drains the FIFO through a valid/ready handshake.

After reset the controller sends its full initial setting set as six bytes. The key input is ignored until that sequence has been queued. The block pulses `key_accept` once for every key press that changed a setting. The mute key affects both speakers together. While mute is on, the stored attenuations are kept, and attenuation keys still move them without sending a byte.

Top module: `rkc_tone_ctrl`

## Requirements
- R1: After reset, `cmd_valid` and `key_accept` are low. The block then queues six bytes in this order: 0x10 (volume 16 steps, -20 dB), 0x80 (left 0 dB), 0xA0 (right 0 dB), 0x44 (loudness off), 0x67 (bass 0 dB), 0x77 (treble 0 dB). Keys presented before the sixth byte has been queued are ignored.
- R2: Code 0 lowers the volume attenuation by one 1.25 dB step and code 1 raises it, within 0 to 63 steps. The byte is 00 in bits 7:6, the steps divided by 8 in bits 5:3 and the steps modulo 8 in bits 2:0.
- R3: Codes 2 and 3 make the left speaker louder or quieter by one 1.25 dB step, within 0 to 30 steps. Codes 4 and 5 do the same for the right speaker. The byte has prefix 100 (left) or 101 (right) in bits 7:5, steps/8 in bits 4:3 and steps mod 8 in bits 2:0.
- R4: Codes 6 and 7 raise or lower treble by 2 dB, and codes 8 and 9 do the same for bass, within -14 to +14 dB. The byte is 0111 (treble) or 0110 (bass) in bits 7:4. Bits 3:0 hold 0 to 7 for -14 to 0 dB and 9 to 15 for +2 to +14 dB. The code 8 never appears.
- R5: Code 10 toggles loudness. It sends 0x40 when loudness turns on and 0x44 when it turns off.
- R6: Code 11 toggles mute. Muting sends 0x9F and then 0xBF one cycle later. Unmuting sends the stored left byte and then the stored right byte.
- R7: While mute is on, attenuation keys change the stored value and pulse `key_accept`, but queue no byte. The new value appears at the next unmute.
- R8: A key that would step a setting past its limit changes nothing, queues nothing and gives no `key_accept`.
- R9: Bytes leave in the order they were queued. `cmd_data` holds steady while `cmd_valid` is high and `cmd_ready` is low.
- R10: A key is dropped when the FIFO is full. A mute key is dropped unless two slots are free. Codes 12 to 15 are ignored. A key in the cycle that queues the second mute byte is ignored.
- R11: `key_accept` is high for exactly the one cycle after the clock edge that took an accepted key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | A key event is present this cycle |
| key_code | input | 4 | Key identifier, codes 0 to 11 |
| cmd_ready | input | 1 | I2C master takes the head byte |
| cmd_valid | output | 1 | A command byte is waiting |
| cmd_data | output | 8 | Head command byte |
| key_accept | output | 1 | One-cycle pulse per accepted key |

## Verification
Every stored setting eventually reaches the ports through the bytes it produces. A wrong step count, a wrong clamp or a lost mute flag shows up in the next byte the setting emits. For a hidden attenuation, the error appears at the next unmute. Errors in FIFO occupancy change which later keys are accepted, so `key_accept` goes wrong within a few cycles. The bench's reference model predicts each cycle's head byte, valid flag and accept pulse, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/rkc_pkg.sv
package rkc_pkg;
  localparam int VOL_W      = 6;
  localparam int ATT_W      = 5;
  localparam int TONE_W     = 4;
  localparam int CMD_W      = 8;
  localparam int KEY_W      = 4;
  localparam int INIT_BYTES = 6;

  typedef enum logic [KEY_W-1:0] {
    K_VOL_UP   = 4'd0,
    K_VOL_DN   = 4'd1,
    K_LEFT_UP  = 4'd2,
    K_LEFT_DN  = 4'd3,
    K_RIGHT_UP = 4'd4,
    K_RIGHT_DN = 4'd5,
    K_TRE_UP   = 4'd6,
    K_TRE_DN   = 4'd7,
    K_BAS_UP   = 4'd8,
    K_BAS_DN   = 4'd9,
    K_LOUD     = 4'd10,
    K_MUTE     = 4'd11
  } key_e;

  // volume: coarse (steps/8) in 5:3, fine (steps%8) in 2:0
  function automatic logic [CMD_W-1:0] vol_cmd(input logic [VOL_W-1:0] steps);
    return {2'b00, steps[5:3], steps[2:0]};
  endfunction

  // speaker: prefix 10x, muted uses all-ones field
  function automatic logic [CMD_W-1:0] spk_cmd(input logic right, input logic muted,
                                               input logic [ATT_W-1:0] steps);
    logic [ATT_W-1:0] fld;
    fld = muted ? {ATT_W{1'b1}} : steps;
    return {2'b10, right, fld[4:3], fld[2:0]};
  endfunction

  // tone level 0..14 (7 = flat); code 8 is skipped
  function automatic logic [CMD_W-1:0] tone_cmd(input logic treble, input logic [TONE_W-1:0] lvl);
    logic [TONE_W-1:0] code;
    code = (lvl > 4'd7) ? lvl + 4'd1 : lvl;
    return {3'b011, treble, code};
  endfunction

  function automatic logic [CMD_W-1:0] loud_cmd(input logic on);
    return {5'b01000, ~on, 2'b00};
  endfunction
endpackage

// File: rtl/rkc_fifo.sv
module rkc_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign count   = count_q;
endmodule

// File: rtl/rkc_key_engine.sv
module rkc_key_engine
  import rkc_pkg::*;
#(
  parameter int VOL_MAX  = 63,
  parameter int VOL_RST  = 16,
  parameter int ATT_MAX  = 30,
  parameter int TONE_MAX = 14,
  parameter int TONE_RST = 7
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 key_valid,
  input  logic [KEY_W-1:0]                     key_code,
  input  logic                                 keys_blocked,
  input  logic                                 room_one,
  input  logic                                 room_two,
  output logic                                 push,
  output logic [CMD_W-1:0]                     push_data,
  output logic                                 key_accept,
  output logic [INIT_BYTES-1:0][CMD_W-1:0]     snap
);
  localparam logic [VOL_W-1:0]  VMAX = VOL_W'(VOL_MAX);
  localparam logic [ATT_W-1:0]  AMAX = ATT_W'(ATT_MAX);
  localparam logic [TONE_W-1:0] TMAX = TONE_W'(TONE_MAX);

  logic [VOL_W-1:0]  vol_q, vol_n;
  logic [ATT_W-1:0]  latt_q, latt_n, ratt_q, ratt_n;
  logic [TONE_W-1:0] tre_q, tre_n, bas_q, bas_n;
  logic              loud_q, loud_n, mute_q, mute_n, pend_q, pend_n, take;

  always_comb begin
    vol_n = vol_q;  latt_n = latt_q; ratt_n = ratt_q;
    tre_n = tre_q;  bas_n = bas_q;   loud_n = loud_q; mute_n = mute_q;
    pend_n = 1'b0;  take = 1'b0;     push = 1'b0;     push_data = '0;
    if (pend_q) begin
      push      = 1'b1;
      push_data = spk_cmd(1'b1, mute_q, ratt_q);
    end else if (key_valid && !keys_blocked && room_one) begin
      case (key_e'(key_code))
        K_VOL_UP: if (vol_q != '0) begin
          vol_n = vol_q - 1'b1; take = 1'b1; push = 1'b1; push_data = vol_cmd(vol_n);
        end
        K_VOL_DN: if (vol_q < VMAX) begin
          vol_n = vol_q + 1'b1; take = 1'b1; push = 1'b1; push_data = vol_cmd(vol_n);
        end
        K_LEFT_UP: if (latt_q != '0) begin
          latt_n = latt_q - 1'b1; take = 1'b1; push = !mute_q;
          push_data = spk_cmd(1'b0, 1'b0, latt_n);
        end
        K_LEFT_DN: if (latt_q < AMAX) begin
          latt_n = latt_q + 1'b1; take = 1'b1; push = !mute_q;
          push_data = spk_cmd(1'b0, 1'b0, latt_n);
        end
        K_RIGHT_UP: if (ratt_q != '0) begin
          ratt_n = ratt_q - 1'b1; take = 1'b1; push = !mute_q;
          push_data = spk_cmd(1'b1, 1'b0, ratt_n);
        end
        K_RIGHT_DN: if (ratt_q < AMAX) begin
          ratt_n = ratt_q + 1'b1; take = 1'b1; push = !mute_q;
          push_data = spk_cmd(1'b1, 1'b0, ratt_n);
        end
        K_TRE_UP: if (tre_q < TMAX) begin
          tre_n = tre_q + 1'b1; take = 1'b1; push = 1'b1; push_data = tone_cmd(1'b1, tre_n);
        end
        K_TRE_DN: if (tre_q != '0) begin
          tre_n = tre_q - 1'b1; take = 1'b1; push = 1'b1; push_data = tone_cmd(1'b1, tre_n);
        end
        K_BAS_UP: if (bas_q < TMAX) begin
          bas_n = bas_q + 1'b1; take = 1'b1; push = 1'b1; push_data = tone_cmd(1'b0, bas_n);
        end
        K_BAS_DN: if (bas_q != '0) begin
          bas_n = bas_q - 1'b1; take = 1'b1; push = 1'b1; push_data = tone_cmd(1'b0, bas_n);
        end
        K_LOUD: begin
          loud_n = !loud_q; take = 1'b1; push = 1'b1; push_data = loud_cmd(loud_n);
        end
        K_MUTE: if (room_two) begin
          mute_n = !mute_q; take = 1'b1; push = 1'b1; pend_n = 1'b1;
          push_data = spk_cmd(1'b0, mute_n, latt_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_q      <= VOL_W'(VOL_RST);
      latt_q     <= '0;
      ratt_q     <= '0;
      tre_q      <= TONE_W'(TONE_RST);
      bas_q      <= TONE_W'(TONE_RST);
      loud_q     <= 1'b0;
      mute_q     <= 1'b0;
      pend_q     <= 1'b0;
      key_accept <= 1'b0;
    end else begin
      vol_q      <= vol_n;
      latt_q     <= latt_n;
      ratt_q     <= ratt_n;
      tre_q      <= tre_n;
      bas_q      <= bas_n;
      loud_q     <= loud_n;
      mute_q     <= mute_n;
      pend_q     <= pend_n;
      key_accept <= take;
    end
  end

  assign snap[0] = vol_cmd(vol_q);
  assign snap[1] = spk_cmd(1'b0, mute_q, latt_q);
  assign snap[2] = spk_cmd(1'b1, mute_q, ratt_q);
  assign snap[3] = loud_cmd(loud_q);
  assign snap[4] = tone_cmd(1'b0, bas_q);
  assign snap[5] = tone_cmd(1'b1, tre_q);
endmodule

// File: rtl/rkc_tone_ctrl.sv
module rkc_tone_ctrl
  import rkc_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int VOL_MAX    = 63,
  parameter int VOL_RST    = 16,
  parameter int ATT_MAX    = 30,
  parameter int TONE_MAX   = 14,
  parameter int TONE_RST   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  output logic             key_accept
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W  = $clog2(INIT_BYTES + 1);

  logic [IDX_W-1:0]                     init_idx;
  logic                                 init_active;
  logic [CMD_W-1:0]                     init_byte, eng_data, wr_data;
  logic                                 eng_push, wr_en, rd_en;
  logic [CNT_W-1:0]                     fifo_count;
  logic [INIT_BYTES-1:0][CMD_W-1:0]     snap;

  assign init_active = (init_idx < IDX_W'(INIT_BYTES));

  always_ff @(posedge clk) begin
    if (rst)              init_idx <= '0;
    else if (init_active) init_idx <= init_idx + 1'b1;
  end

  always_comb begin
    init_byte = '0;
    for (int i = 0; i < INIT_BYTES; i++)
      if (init_idx == IDX_W'(i)) init_byte = snap[i];
  end

  rkc_key_engine #(
    .VOL_MAX(VOL_MAX), .VOL_RST(VOL_RST), .ATT_MAX(ATT_MAX),
    .TONE_MAX(TONE_MAX), .TONE_RST(TONE_RST)
  ) u_engine (
    .clk          (clk),
    .rst          (rst),
    .key_valid    (key_valid),
    .key_code     (key_code),
    .keys_blocked (init_active),
    .room_one     (fifo_count < CNT_W'(FIFO_DEPTH)),
    .room_two     (fifo_count <= CNT_W'(FIFO_DEPTH - 2)),
    .push         (eng_push),
    .push_data    (eng_data),
    .key_accept   (key_accept),
    .snap         (snap)
  );

  assign wr_en   = init_active | eng_push;
  assign wr_data = init_active ? init_byte : eng_data;
  assign rd_en   = cmd_valid & cmd_ready;

  rkc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CMD_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (cmd_data),
    .count   (fifo_count)
  );

  assign cmd_valid = (fifo_count != '0);
endmodule

// File: rtl/rkc_tone_ctrl_chk.sv
module rkc_tone_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          key_valid,
  input logic          cmd_ready,
  input logic          cmd_valid,
  input logic [7:0]    cmd_data,
  input logic          key_accept,
  input logic          init_active,
  input logic [CW-1:0] fifo_count
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_valid && !key_accept)); // R1

  AST_INIT_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $past(init_active) |-> !key_accept); // R1

  AST_ACCEPT_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    key_accept |-> $past(key_valid)); // R11

  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R9

  AST_TONE_SKIP_CODE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_data[7:5] == 3'b011) |-> (cmd_data[3:0] != 4'b1000)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH)); // R10
endmodule

bind rkc_tone_ctrl rkc_tone_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_valid   (key_valid),
  .cmd_ready   (cmd_ready),
  .cmd_valid   (cmd_valid),
  .cmd_data    (cmd_data),
  .key_accept  (key_accept),
  .init_active (init_active),
  .fifo_count  (fifo_count)
);

// File: tb/test_rkc_tone_ctrl.sv
module test_rkc_tone_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_valid = 1'b0;
  logic [3:0] key_code = '0;
  logic       cmd_ready = 1'b1;
  logic       cmd_valid, key_accept;
  logic [7:0] cmd_data;

  int checks = 0, failures = 0;
  bit chk_en = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rkc_tone_ctrl #(.FIFO_DEPTH(DEPTH)) i_rkc_tone_ctrl (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .key_accept(key_accept)
  );

  // ---------------- reference model ----------------
  int q[$];
  int m_vol, m_l, m_r, m_tre, m_bas, m_init, cnt;
  bit m_loud, m_mute, m_pend, m_acc;

  function automatic int spk_b(bit right, bit muted, int steps);
    return 128 + (right ? 32 : 0) + (muted ? 31 : steps);
  endfunction
  function automatic int tone_b(bit treble, int lvl);
    return 96 + (treble ? 16 : 0) + ((lvl <= 7) ? lvl : lvl + 1);
  endfunction
  function automatic int loud_b(bit on);
    return on ? 64 : 68;
  endfunction

  always @(posedge clk) begin
    cnt = q.size();
    m_acc = 0;
    if (rst) begin
      q.delete();
      m_vol = 16; m_l = 0; m_r = 0; m_tre = 7; m_bas = 7;
      m_loud = 0; m_mute = 0; m_init = 0; m_pend = 0;
    end else begin
      if (cnt > 0 && cmd_ready) void'(q.pop_front());
      if (m_init < 6) begin
        case (m_init)
          0: q.push_back(m_vol);
          1: q.push_back(spk_b(0, 0, m_l));
          2: q.push_back(spk_b(1, 0, m_r));
          3: q.push_back(loud_b(m_loud));
          4: q.push_back(tone_b(0, m_bas));
          default: q.push_back(tone_b(1, m_tre));
        endcase
        m_init++;
      end else if (m_pend) begin
        q.push_back(spk_b(1, m_mute, m_r));
        m_pend = 0;
      end else if (key_valid && cnt < DEPTH) begin
        case (key_code)
          0: if (m_vol > 0)  begin m_vol--; m_acc = 1; q.push_back(m_vol); end
          1: if (m_vol < 63) begin m_vol++; m_acc = 1; q.push_back(m_vol); end
          2: if (m_l > 0)  begin m_l--; m_acc = 1; if (!m_mute) q.push_back(spk_b(0, 0, m_l)); end
          3: if (m_l < 30) begin m_l++; m_acc = 1; if (!m_mute) q.push_back(spk_b(0, 0, m_l)); end
          4: if (m_r > 0)  begin m_r--; m_acc = 1; if (!m_mute) q.push_back(spk_b(1, 0, m_r)); end
          5: if (m_r < 30) begin m_r++; m_acc = 1; if (!m_mute) q.push_back(spk_b(1, 0, m_r)); end
          6: if (m_tre < 14) begin m_tre++; m_acc = 1; q.push_back(tone_b(1, m_tre)); end
          7: if (m_tre > 0)  begin m_tre--; m_acc = 1; q.push_back(tone_b(1, m_tre)); end
          8: if (m_bas < 14) begin m_bas++; m_acc = 1; q.push_back(tone_b(0, m_bas)); end
          9: if (m_bas > 0)  begin m_bas--; m_acc = 1; q.push_back(tone_b(0, m_bas)); end
          10: begin m_loud = !m_loud; m_acc = 1; q.push_back(loud_b(m_loud)); end
          11: if (cnt <= DEPTH - 2) begin
                m_mute = !m_mute; m_acc = 1; m_pend = 1;
                q.push_back(spk_b(0, m_mute, m_l));
              end
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (cmd_valid !== (q.size() != 0)) begin
        failures++;
        $display("FAIL %s cmd_valid actual=%b expected=%b", tag, cmd_valid, q.size() != 0);
      end
      checks++;
      if (key_accept !== m_acc) begin
        failures++;
        $display("FAIL %s key_accept actual=%b expected=%b", tag, key_accept, m_acc);
      end
      if (q.size() != 0) begin
        checks++;
        if (cmd_data !== 8'(q[0])) begin
          failures++;
          $display("FAIL %s cmd_data actual=%02h expected=%02h", tag, cmd_data, 8'(q[0]));
        end
      end
    end
  end

  task automatic press(input int code, input int gap = 1);
    @(negedge clk); key_valid = 1'b1; key_code = 4'(code);
    @(negedge clk); key_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic press_n(input int code, input int n);
    for (int i = 0; i < n; i++) press(code);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_en = 1;
    // R1: reset state explicitly
    checks++;
    if (cmd_valid !== 1'b0 || key_accept !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", cmd_valid, key_accept);
    end
    rst = 1'b0;
    // R1: key during init sequence is ignored
    tag = "R1";
    @(negedge clk); key_valid = 1'b1; key_code = 4'd0;
    repeat (3) @(negedge clk); key_valid = 1'b0;
    repeat (12) @(negedge clk);
    // R2: volume up to the top, then down to the bottom
    tag = "R2"; press_n(0, 14);
    tag = "R8"; press_n(0, 4);
    tag = "R2"; press_n(1, 66);
    tag = "R8"; press_n(1, 3);
    // R3: speaker attenuation
    tag = "R3"; press_n(3, 28); press_n(5, 9); press_n(2, 2);
    tag = "R8"; press_n(3, 6); press_n(4, 12);
    // R6 / R7: mute with attenuation changes while muted
    tag = "R6"; press(11, 2);
    tag = "R7"; press_n(2, 3); press_n(5, 2);
    tag = "R6"; press(11, 2); press(11, 2); press(11, 2);
    // R4: tone ranges
    tag = "R4"; press_n(6, 9); press_n(7, 16); press_n(8, 3); press_n(9, 10);
    tag = "R8"; press_n(9, 2); press_n(8, 20);
    // R5: loudness toggle
    tag = "R5"; press_n(10, 3);
    // R10: unused codes
    tag = "R10"; press_n(12, 1); press_n(13, 1); press_n(14, 1); press_n(15, 1);
    // R9 / R10: stall the output, fill, try mute near full
    tag = "R9"; @(negedge clk); cmd_ready = 1'b0;
    press_n(1, 6);
    tag = "R10"; press(11, 1); press(0, 1); press(11, 1); press_n(0, 4);
    repeat (5) @(negedge clk); cmd_ready = 1'b1;
    repeat (12) @(negedge clk);
    // R10 / R11: back-to-back keys, including one in the second-mute cycle
    tag = "R11";
    @(negedge clk); key_valid = 1'b1; key_code = 4'd11;
    @(negedge clk); key_code = 4'd0;
    @(negedge clk); key_code = 4'd1;
    @(negedge clk); key_code = 4'd11;
    @(negedge clk); key_code = 4'd10;
    @(negedge clk); key_valid = 1'b0;
    repeat (10) @(negedge clk);
    // mixed traffic with a stalling consumer
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      key_valid = ($urandom % 2) == 0;
      key_code  = 4'($urandom % 16);
      cmd_ready = ($urandom % 4) != 0;
    end
    @(negedge clk); key_valid = 1'b0; cmd_ready = 1'b1;
    repeat (12) @(negedge clk);
    // R1 again after a mid-run reset
    tag = "R1"; chk_en = 0; do_reset(); chk_en = 1;
    repeat (12) @(negedge clk);
    summary();
  end
endmodule